// File: doc/BRIEF.md
# Boundary Cell Counting Pattern Generator

This block produces the serial load patterns that give every cell of a boundary register its own activity signature. Cells are numbered from 1 up to the cell count C. The block computes the number of patterns P as ceil(log2(C+2)). For pattern k it streams one full register load of C bits, and the bit meant for cell n equals bit k of n. Across the P loads each cell therefore carries a binary identifier. The bound C+2 keeps every identifier away from the all-zeros and all-ones series, so no cell can be confused with a stuck cell.

Bits leave in shift order: the cell nearest the serial output is loaded first, so each pattern starts with cell C and ends with cell 1. The stream uses a valid/ready handshake. It carries the cell number, the pattern index, a marker for the last bit of each pattern and a marker for the final pattern. A separate decode path takes the P samples observed for one cell, with sample k in bit k, and rebuilds the cell number. It flags a result of 0 or above C as invalid.

The control state machine has three states:
- ST_IDLE goes to ST_SIZE when start is high and cell_count is non-zero, and latches C.
- ST_SIZE always goes to ST_STREAM on the next cycle, after latching P from a leading-one detector.
- ST_STREAM steps down through the cells and then up through the patterns on each accepted bit. It returns to ST_IDLE after the last bit of the final pattern is accepted.

Top module: `cpg_counting_gen`

## Requirements
- R1: After reset, out_valid, busy, dec_valid and pat_total are all 0.
- R2: Once a job has been sized, pat_total equals ceil(log2(C+2)) for the latched C; streaming begins two clock edges after start is sampled.
- R3: Within one pattern, out_cell runs from C down to 1, one cell per accepted bit, and out_bit is bit out_pat of out_cell.
- R4: Patterns run in order from out_pat=0 to P-1, and out_pat is always below pat_total; a job moves exactly C*P bits.
- R5: out_last_bit is high exactly when out_cell is 1; out_last_pat is high for every bit of pattern P-1 and for no other bit.
- R6: While out_valid is high and out_ready is low, out_valid, out_cell, out_pat and out_bit hold their values.
- R7: The cycle after the final bit is accepted, out_valid and busy are 0. A start with cell_count 0, or a start while busy, is ignored.
- R8: Over the P patterns, the bit series for each cell is unique and is neither all zeros nor all ones across the P bits.
- R9: dec_valid pulses one cycle after dec_req. dec_cell equals dec_samples with every bit at position P or above cleared, where P and C come from the most recent sized job (P=0 and C=0 before any job). dec_ok is 1 only if that value lies in 1..C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job with the count on cell_count |
| cell_count | input | CNT_W | Number of boundary cells C |
| out_ready | input | 1 | Consumer accepts the current bit |
| out_valid | output | 1 | A pattern bit is offered |
| out_bit | output | 1 | Pattern bit for the current cell |
| out_pat | output | PAT_W | Current pattern index k |
| out_cell | output | CNT_W | Cell number the bit belongs to |
| out_last_bit | output | 1 | Last bit of the current pattern (cell 1) |
| out_last_pat | output | 1 | Current pattern is the final one |
| busy | output | 1 | A job is in progress |
| pat_total | output | PAT_W | Pattern count P of the latest job |
| dec_req | input | 1 | Decode the samples on dec_samples |
| dec_samples | input | CNT_W+1 | Observed series, sample k in bit k |
| dec_valid | output | 1 | Decode result valid |
| dec_cell | output | CNT_W+1 | Rebuilt cell number |
| dec_ok | output | 1 | Rebuilt number lies in 1..C |

## Verification
A wrong cell counter shows on out_cell or out_bit at the very next accepted bit. A wrong pattern counter or pattern size shows at the first wrap: out_pat skips or runs past pat_total, or the final-pattern marker appears at the wrong time. A state machine stuck in streaming keeps out_valid high in the cycle after the final bit. A bad pattern bit also breaks the per-cell series, and the uniqueness check over every cell catches it only when the job ends.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SIZE   = 2'd1,
        ST_STREAM = 2'd2
    } cpg_state_t;

endpackage

// File: rtl/cpg_pat_count.sv
module cpg_pat_count #(
    parameter int CNT_W = 12,
    parameter int PAT_W = 4
) (
    input  logic [CNT_W-1:0] cells,
    output logic [PAT_W-1:0] pat_num
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] plus_one;
    logic [EXT_W-1:0] top_hit;

    // P = ceil(log2(C+2)) equals the bit length of C+1
    assign plus_one = {1'b0, cells} + EXT_W'(1);

    genvar gi;
    generate
        for (gi = 0; gi < EXT_W; gi++) begin : g_lod
            if (gi == EXT_W - 1) begin : g_msb
                assign top_hit[gi] = plus_one[gi];
            end else begin : g_low
                assign top_hit[gi] = plus_one[gi] & ~(|plus_one[EXT_W-1:gi+1]);
            end
        end
    endgenerate

    always_comb begin
        pat_num = '0;
        for (int i = 0; i < EXT_W; i++) begin
            if (top_hit[i]) pat_num = PAT_W'(i + 1);
        end
    end

endmodule

// File: rtl/cpg_stream_fsm.sv
module cpg_stream_fsm
    import cpg_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int PAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cell_count,
    input  logic [PAT_W-1:0] pat_num_in,
    output logic [CNT_W-1:0] c_reg,
    output logic [PAT_W-1:0] p_reg,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_bit,
    output logic [PAT_W-1:0] out_pat,
    output logic [CNT_W-1:0] out_cell,
    output logic             out_last_bit,
    output logic             out_last_pat,
    output logic             busy
);
    localparam int EXT_W = CNT_W + 1;

    cpg_state_t       state, state_nxt;
    logic [CNT_W-1:0] cell_q;
    logic [PAT_W-1:0] pat_q;
    logic             fire;
    logic             at_cell_one;
    logic             at_final_pat;
    logic [EXT_W-1:0] cell_shift;

    assign at_cell_one  = (cell_q == CNT_W'(1));
    assign at_final_pat = (pat_q == p_reg - PAT_W'(1));
    assign fire         = (state == ST_STREAM) && out_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start && (cell_count != '0)) state_nxt = ST_SIZE;
            ST_SIZE:   state_nxt = ST_STREAM;
            ST_STREAM: if (fire && at_cell_one && at_final_pat) state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // counters and latched job size
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_reg  <= '0;
            p_reg  <= '0;
            cell_q <= '0;
            pat_q  <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start && (cell_count != '0)) c_reg <= cell_count;
                end
                ST_SIZE: begin
                    p_reg  <= pat_num_in;
                    cell_q <= c_reg;
                    pat_q  <= '0;
                end
                ST_STREAM: begin
                    if (fire) begin
                        if (at_cell_one) begin
                            cell_q <= c_reg;
                            pat_q  <= pat_q + PAT_W'(1);
                        end else begin
                            cell_q <= cell_q - CNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cell_shift   = {1'b0, cell_q} >> pat_q;
        out_valid    = (state == ST_STREAM);
        out_bit      = out_valid & cell_shift[0];
        out_pat      = pat_q;
        out_cell     = cell_q;
        out_last_bit = out_valid & at_cell_one;
        out_last_pat = out_valid & at_final_pat;
        busy         = (state != ST_IDLE);
    end

    p_min_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STREAM) |->
            ((int'(c_reg) + 2 <= (1 << p_reg)) && (int'(c_reg) + 2 > (1 << (p_reg - PAT_W'(1))))));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last_bit) |=>
            ((out_cell == $past(out_cell) - CNT_W'(1)) && (out_pat == $past(out_pat))));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last_bit && !out_last_pat) |=>
            ((out_cell == c_reg) && (out_pat == $past(out_pat) + PAT_W'(1))));

    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_pat < p_reg));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_cell) && $stable(out_pat) && $stable(out_bit)));

    p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last_bit && out_last_pat) |=> (!out_valid && !busy));

endmodule

// File: rtl/cpg_decoder.sv
module cpg_decoder #(
    parameter int CNT_W = 12,
    parameter int PAT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dec_req,
    input  logic [CNT_W:0]   dec_samples,
    input  logic [CNT_W-1:0] c_reg,
    input  logic [PAT_W-1:0] p_reg,
    output logic             dec_valid,
    output logic [CNT_W:0]   dec_cell,
    output logic             dec_ok
);
    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] keep_mask;
    logic [EXT_W-1:0] masked;

    genvar gi;
    generate
        for (gi = 0; gi < EXT_W; gi++) begin : g_mask
            assign keep_mask[gi] = (PAT_W'(gi) < p_reg);
        end
    endgenerate

    assign masked = dec_samples & keep_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid <= 1'b0;
            dec_cell  <= '0;
            dec_ok    <= 1'b0;
        end else begin
            dec_valid <= dec_req;
            if (dec_req) begin
                dec_cell <= masked;
                dec_ok   <= (masked != '0) && (masked <= {1'b0, c_reg});
            end
        end
    end

    p_ok_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_ok) |-> ((dec_cell != '0) && (dec_cell <= {1'b0, $past(c_reg)})));

endmodule

// File: rtl/cpg_counting_gen.sv
module cpg_counting_gen #(
    parameter int CNT_W = 12,
    parameter int PAT_W = $clog2(CNT_W + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cell_count,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_bit,
    output logic [PAT_W-1:0] out_pat,
    output logic [CNT_W-1:0] out_cell,
    output logic             out_last_bit,
    output logic             out_last_pat,
    output logic             busy,
    output logic [PAT_W-1:0] pat_total,
    input  logic             dec_req,
    input  logic [CNT_W:0]   dec_samples,
    output logic             dec_valid,
    output logic [CNT_W:0]   dec_cell,
    output logic             dec_ok
);
    logic [CNT_W-1:0] c_reg;
    logic [PAT_W-1:0] p_reg;
    logic [PAT_W-1:0] pat_num;

    cpg_pat_count #(.CNT_W(CNT_W), .PAT_W(PAT_W)) u_count (
        .cells   (c_reg),
        .pat_num (pat_num)
    );

    cpg_stream_fsm #(.CNT_W(CNT_W), .PAT_W(PAT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cell_count   (cell_count),
        .pat_num_in   (pat_num),
        .c_reg        (c_reg),
        .p_reg        (p_reg),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_bit      (out_bit),
        .out_pat      (out_pat),
        .out_cell     (out_cell),
        .out_last_bit (out_last_bit),
        .out_last_pat (out_last_pat),
        .busy         (busy)
    );

    cpg_decoder #(.CNT_W(CNT_W), .PAT_W(PAT_W)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_req     (dec_req),
        .dec_samples (dec_samples),
        .c_reg       (c_reg),
        .p_reg       (p_reg),
        .dec_valid   (dec_valid),
        .dec_cell    (dec_cell),
        .dec_ok      (dec_ok)
    );

    assign pat_total = p_reg;

endmodule

// File: tb/sim_cpg_counting_gen.sv
module sim_cpg_counting_gen;
    localparam int CNT_W = 12;
    localparam int PAT_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] cell_count = '0;
    logic             out_ready = 1'b0;
    logic             out_valid, out_bit, out_last_bit, out_last_pat, busy;
    logic [PAT_W-1:0] out_pat, pat_total;
    logic [CNT_W-1:0] out_cell;
    logic             dec_req = 1'b0;
    logic [CNT_W:0]   dec_samples = '0;
    logic             dec_valid, dec_ok;
    logic [CNT_W:0]   dec_cell;

    int errors = 0;
    int checks = 0;
    int last_p = 0;
    int last_c = 0;

    logic [CNT_W:0] sig [0:4095];
    bit             seen [0:8191];

    always #4 clk = ~clk;

    cpg_counting_gen #(.CNT_W(CNT_W)) u0 (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pats(input int c);
        int p = 0;
        while ((1 << p) < c + 2) p++;
        return p;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(dec_valid == 1'b0, "R1 dec_valid after reset", int'(dec_valid), 0);
        chk(pat_total == '0, "R1 pat_total after reset", int'(pat_total), 0);
    endtask

    // stall: 1 gives a ready pattern with gaps; inject: ignored start mid-job
    task automatic t_job(input int c, input bit stall, input bit inject);
        int p = exp_pats(c);
        int ek = 0;
        int en = c;
        int moved = 0;
        int bad_stream = 0;
        int bad_mark = 0;
        int bad_hold = 0;
        int guard = 0;
        int cyc = 0;
        bit done = 0;
        bit held = 0;
        logic [CNT_W-1:0] h_cell;
        logic [PAT_W-1:0] h_pat;
        logic             h_bit;
        int bad_sig = 0;
        logic [CNT_W:0] ones;

        for (int i = 0; i < 4096; i++) sig[i] = '0;
        for (int i = 0; i < 8192; i++) seen[i] = 1'b0;

        start = 1'b1;
        cell_count = CNT_W'(c);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1 && out_valid == 1'b0, "R2 sizing cycle busy", int'(busy), 1);
        @(negedge clk);
        chk(out_valid == 1'b1, "R2 stream starts", int'(out_valid), 1);
        chk(int'(pat_total) == p, "R2 pattern count", int'(pat_total), p);

        while (!done && guard < c * p * 4 + 50) begin
            bit r;
            guard++;
            cyc++;
            if (held) begin
                if (!(out_valid && out_cell == h_cell && out_pat == h_pat && out_bit == h_bit)) bad_hold++;
            end
            r = stall ? ((cyc % 3) != 2) : 1'b1;
            out_ready = r;
            if (inject && moved == 3) begin
                start = 1'b1;
                cell_count = CNT_W'(2);
            end else begin
                start = 1'b0;
            end
            if (out_valid) begin
                if (r) begin
                    bit eb = ((en >> ek) & 1) != 0;
                    if (int'(out_cell) != en || int'(out_pat) != ek || out_bit != eb) begin
                        if (bad_stream == 0)
                            $display("  stream mismatch C=%0d cell %0d/%0d pat %0d/%0d bit %0d/%0d",
                                     c, out_cell, en, out_pat, ek, out_bit, eb);
                        bad_stream++;
                    end
                    if (out_last_bit != (en == 1) || out_last_pat != (ek == p - 1)) bad_mark++;
                    if (en >= 1 && en <= 4095 && ek <= CNT_W) sig[en][ek] = out_bit;
                    moved++;
                    if (out_last_bit && out_last_pat) done = 1;
                    if (en == 1) begin en = c; ek++; end
                    else en--;
                    held = 0;
                end else begin
                    held = 1;
                    h_cell = out_cell;
                    h_pat  = out_pat;
                    h_bit  = out_bit;
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        out_ready = 1'b0;

        chk(bad_stream == 0, "R3 cell order and bit value", bad_stream, 0);
        chk(moved == c * p, "R4 bits per job", moved, c * p);
        chk(bad_mark == 0, "R5 last-bit and last-pattern markers", bad_mark, 0);
        if (stall) chk(bad_hold == 0, "R6 hold under backpressure", bad_hold, 0);
        chk(out_valid == 1'b0 && busy == 1'b0, "R7 idle after final bit", int'(busy), 0);
        if (inject) chk(int'(pat_total) == p, "R7 start while busy ignored", int'(pat_total), p);

        ones = (CNT_W + 1)'((1 << p) - 1);
        for (int n = 1; n <= c; n++) begin
            if (sig[n] == '0 || sig[n] == ones || seen[sig[n]]) bad_sig++;
            seen[sig[n]] = 1'b1;
        end
        chk(bad_sig == 0, "R8 unique non-constant series per cell", bad_sig, 0);
        last_p = p;
        last_c = c;
    endtask

    task automatic t_zero_start();
        int p0 = int'(pat_total);
        start = 1'b1;
        cell_count = '0;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R7 zero-count start ignored (busy)", int'(busy), 0);
        @(negedge clk);
        chk(out_valid == 1'b0 && int'(pat_total) == p0, "R7 zero-count start ignored (stream)",
            int'(pat_total), p0);
    endtask

    task automatic t_decode(input int samples);
        int ec = samples & ((1 << last_p) - 1);
        bit eok = (ec != 0) && (ec <= last_c);
        dec_req = 1'b1;
        dec_samples = (CNT_W + 1)'(samples);
        @(negedge clk);
        dec_req = 1'b0;
        chk(dec_valid == 1'b1, "R9 decode valid", int'(dec_valid), 1);
        chk(int'(dec_cell) == ec, "R9 decoded cell", int'(dec_cell), ec);
        chk(dec_ok == eok, "R9 decode range flag", int'(dec_ok), int'(eok));
        @(negedge clk);
        chk(dec_valid == 1'b0, "R9 decode valid is a pulse", int'(dec_valid), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_decode(1);                   // R9: no job yet, nothing valid
        t_job(1, 1'b0, 1'b0);
        t_job(5, 1'b1, 1'b0);
        t_job(6, 1'b0, 1'b1);
        t_decode(5);
        t_decode(13'h1003);            // R9: upper garbage bits cleared
        t_decode(7);
        t_decode(0);
        t_zero_start();
        t_job(7, 1'b1, 1'b1);
        t_job(4095, 1'b0, 1'b0);
        t_decode(4095);
        t_decode(4096);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule